// File: doc/BRIEF.md
# Stipple and Blit Pixel Drawing Engine

This block speeds up drawing into an 8-bit-per-pixel frame buffer. A host issues 32-bit register writes into one of two command windows. In the stipple window, a 32-bit mask paints a row of up to 32 pixels with a stored colour. In the blit window, a command either fills a run of 1 to 32 pixels with that colour or copies a run from a source pixel address to a destination. The command is carried by the write address. When address bit 2 is clear, the write only stores a colour. When it is set, the write starts an operation, and the upper address bits give the destination pixel.

The engine owns one single-port pixel memory port. Its reads return data one cycle after the request. Fills and stipples write one pixel per clock. A copy spends a read cycle and then a write cycle on each pixel, in ascending address order. This makes overlapping runs behave like a forward byte copy. While an operation runs, `busy_o` is high and `cmd_ready_o` is low, so any further command is held off until the engine is idle.

Top module: `pix_draw_engine`

## Requirements
- R1: An accepted write with address bit 2 clear only stores its data as the colour, of which bits 7:0 are the pixel value. It makes no memory request and does not raise busy.
- R2: An accepted write with address bit 2 set starts an operation whose destination pixel address is taken from address bits ADDR_W+2:3.
- R3: In a stipple operation (window select 0), the pixel at destination+i receives the colour when mask bit 31-i is set, and it is left untouched when that bit is clear.
- R4: A stipple operation keeps busy high for exactly 32 cycles, whatever the mask is.
- R5: In a blit operation (window select 1), data bits 23:0 are the source address and bits 28:24 are the run length minus one. Only the low ADDR_W bits of the source address reach memory.
- R6: A blit whose source field is 0xFFFFFF fills the run at the destination with the colour, and busy stays high for length cycles.
- R7: Any other blit copies the run in ascending order. Each source pixel is read before the matching destination pixel is written, so overlapping runs act as a forward byte copy. Busy stays high for 2×length cycles.
- R8: Reads (write enable low) in either window return zero on `rd_data_o` and change neither memory, colour nor busy.
- R9: Busy rises in the cycle after the triggering write is accepted and falls after the last pixel cycle. The ready signal is low while busy, so a command held valid meanwhile is taken only once the engine is idle. A memory request is made only while busy.
- R10: Destination and source pixel addresses wrap modulo 2^ADDR_W.
- R11: After reset, busy is low, ready is high, no memory request is made, and the colour is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command access present |
| cmd_ready_o | output | 1 | Engine can take an access |
| cmd_win_i | input | 1 | Window select: 0 stipple, 1 blit |
| cmd_we_i | input | 1 | 1 write, 0 read |
| cmd_addr_i | input | ADDR_W+3 | Byte address within the window |
| cmd_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, always zero |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Pixel memory request |
| mem_we_o | output | 1 | Pixel memory write enable |
| mem_addr_o | output | ADDR_W | Pixel memory address |
| mem_wdata_o | output | PIX_W | Pixel write data |
| mem_rdata_i | input | PIX_W | Pixel read data, one cycle after a read request |

## Verification
Several properties are checked on every cycle by the assertions. The colour cannot change during an operation. No memory request happens outside busy. Busy follows every trigger. Each copy write comes right after a read. Consecutive fill writes step the address by one, wrapping at the top. Only the bench's scenarios can show the drawn pixels themselves. It sweeps masks, every run length, overlapping copies in both directions and wrapped addresses against a reference frame buffer. It also times busy for each command kind, counts memory requests, and demonstrates that a command held during busy is stalled and then taken.

// File: rtl/pix_draw_pkg.sv
package pix_draw_pkg;
  localparam int unsigned CMD_W  = 32;
  localparam int unsigned MASK_W = 32;
  localparam int unsigned SRC_W  = 24;
  localparam int unsigned RUN_W  = 5;
  localparam int unsigned CNT_W  = $clog2(MASK_W);
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned DST_LSB  = 3;

  typedef enum logic [1:0] {
    OP_STIP,
    OP_FILL,
    OP_COPY
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STIP,
    ST_FILL,
    ST_CP_RD,
    ST_CP_WR
  } eng_state_e;
endpackage

// File: rtl/pix_cmd_decode.sv
module pix_cmd_decode
  import pix_draw_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PIX_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                win_i,
  input  logic [ADDR_W+2:0]   addr_i,
  input  logic [CMD_W-1:0]    data_i,
  input  logic                busy_i,
  output logic                start_o,
  output op_kind_e            kind_o,
  output logic [ADDR_W-1:0]   dst_o,
  output logic [ADDR_W-1:0]   src_o,
  output logic [RUN_W-1:0]    len_m1_o,
  output logic [MASK_W-1:0]   mask_o,
  output logic [PIX_W-1:0]    colour_o
);
  logic [PIX_W-1:0] colour_q;
  logic             is_fill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         colour_q <= '0;
    else if (accept_i && !addr_i[TRIG_BIT]) colour_q <= data_i[PIX_W-1:0];
  end

  assign is_fill  = (data_i[SRC_W-1:0] == {SRC_W{1'b1}});
  assign start_o  = accept_i && addr_i[TRIG_BIT];
  assign dst_o    = addr_i[ADDR_W+DST_LSB-1:DST_LSB];
  assign src_o    = data_i[ADDR_W-1:0];
  assign len_m1_o = data_i[SRC_W+RUN_W-1:SRC_W];
  assign mask_o   = data_i[MASK_W-1:0];
  assign colour_o = colour_q;

  always_comb begin
    if (!win_i)       kind_o = OP_STIP;
    else if (is_fill) kind_o = OP_FILL;
    else              kind_o = OP_COPY;
  end

  assert_colour_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(colour_q));
endmodule

// File: rtl/pix_sequencer.sv
module pix_sequencer
  import pix_draw_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PIX_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  op_kind_e            kind_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [RUN_W-1:0]    len_m1_i,
  input  logic [MASK_W-1:0]   mask_i,
  input  logic [PIX_W-1:0]    colour_i,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [PIX_W-1:0]    mem_wdata_o,
  input  logic [PIX_W-1:0]    mem_rdata_i
);
  localparam logic [CNT_W-1:0] STIP_LAST = CNT_W'(MASK_W - 1);

  eng_state_e        state_q;
  logic [ADDR_W-1:0] dst_q, src_q;
  logic [MASK_W-1:0] mask_q;
  logic [CNT_W-1:0]  cnt_q, len_q;
  logic              run_last;

  assign run_last = (cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          dst_q  <= dst_i;
          src_q  <= src_i;
          mask_q <= mask_i;
          len_q  <= CNT_W'(len_m1_i);
          cnt_q  <= '0;
          unique case (kind_i)
            OP_STIP: state_q <= ST_STIP;
            OP_FILL: state_q <= ST_FILL;
            default: state_q <= ST_CP_RD;
          endcase
        end
        ST_STIP: begin
          mask_q <= mask_q << 1;
          dst_q  <= dst_q + 1'b1;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == STIP_LAST) state_q <= ST_IDLE;
        end
        ST_FILL: begin
          dst_q <= dst_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (run_last) state_q <= ST_IDLE;
        end
        ST_CP_RD: state_q <= ST_CP_WR;
        ST_CP_WR: begin
          dst_q <= dst_q + 1'b1;
          src_q <= src_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
          state_q <= run_last ? ST_IDLE : ST_CP_RD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // stipple: skip pixels whose mask bit is clear
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b1;
    mem_addr_o  = dst_q;
    mem_wdata_o = colour_i;
    unique case (state_q)
      ST_STIP:  mem_req_o = mask_q[MASK_W-1];
      ST_FILL:  mem_req_o = 1'b1;
      ST_CP_RD: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b0;
        mem_addr_o = src_q;
      end
      ST_CP_WR: begin
        mem_req_o   = 1'b1;
        mem_wdata_o = mem_rdata_i;
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_copy_read_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CP_WR) |-> $past(mem_req_o && !mem_we_o));

  assert_fill_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && $past(state_q) == ST_FILL)
      |-> mem_addr_o == $past(mem_addr_o) + 1'b1);
endmodule

// File: rtl/pix_draw_engine.sv
module pix_draw_engine
  import pix_draw_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PIX_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_win_i,
  input  logic               cmd_we_i,
  input  logic [ADDR_W+2:0]  cmd_addr_i,
  input  logic [CMD_W-1:0]   cmd_wdata_i,
  output logic [CMD_W-1:0]   rd_data_o,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [PIX_W-1:0]   mem_wdata_o,
  input  logic [PIX_W-1:0]   mem_rdata_i
);
  logic              accept, start;
  op_kind_e          kind;
  logic [ADDR_W-1:0] dst, src;
  logic [RUN_W-1:0]  len_m1;
  logic [MASK_W-1:0] mask;
  logic [PIX_W-1:0]  colour;

  assign cmd_ready_o = !busy_o;
  assign accept      = cmd_valid_i && cmd_ready_o && cmd_we_i;
  assign rd_data_o   = '0;

  pix_cmd_decode #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .win_i    (cmd_win_i),
    .addr_i   (cmd_addr_i),
    .data_i   (cmd_wdata_i),
    .busy_i   (busy_o),
    .start_o  (start),
    .kind_o   (kind),
    .dst_o    (dst),
    .src_o    (src),
    .len_m1_o (len_m1),
    .mask_o   (mask),
    .colour_o (colour)
  );

  pix_sequencer #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .kind_i      (kind),
    .dst_i       (dst),
    .src_i       (src),
    .len_m1_i    (len_m1),
    .mask_i      (mask),
    .colour_i    (colour),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o);

  assert_req_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

// File: tb/tb_pix_draw_engine.sv
module tb_pix_draw_engine;
  localparam int AW  = 10;
  localparam int N   = 1 << AW;
  localparam int BAW = AW + 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_win = 0, cmd_we = 0;
  logic [BAW-1:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic cmd_ready, busy, mem_req, mem_we;
  logic [31:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic init_en = 0;

  logic [7:0] mem [N];
  logic [7:0] exp_mem [N];
  int req_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] colour = 8'h00;

  always #10 clk = ~clk;

  pix_draw_engine #(.ADDR_W(AW), .PIX_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_win_i(cmd_win), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rd_data_o(rd_data), .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (init_en) for (int a = 0; a < N; a++) mem[a] <= pat(a);
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    else if (mem_req) mem_rdata <= mem[mem_addr];
    if (mem_req) req_cnt <= req_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus(input bit win, input logic [BAW-1:0] addr, input logic [31:0] data,
                     input bit we, output logic [31:0] rd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_win = win; cmd_addr = addr; cmd_wdata = data; cmd_we = we;
    #1 rd = rd_data;
    @(negedge clk);
    cmd_valid = 0; cmd_we = 0;
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0, first = -1;
    for (int a = 0; a < N; a++) if (mem[a] !== exp_mem[a]) begin
      bad++; if (first < 0) first = a;
    end
    if (first < 0) chk(1, req, "memory", 0, 0);
    else chk(0, req, $sformatf("memory mismatches at pixel %0d", first),
             int'(mem[first]), int'(exp_mem[first]));
  endtask

  task automatic wait_busy(input int exp_cycles, input string req);
    int n = 0;
    bit rdy_bad = 0;
    while (busy) begin
      if (cmd_ready) rdy_bad = 1;
      n++;
      @(negedge clk);
    end
    chk(n == exp_cycles, req, "busy cycles", n, exp_cycles);
    chk(!rdy_bad, "R9", "ready low during busy", int'(rdy_bad), 0);
  endtask

  task automatic set_colour(input logic [31:0] c, input logic [AW-1:0] junk);
    logic [31:0] rd;
    int r0 = req_cnt;
    bus(1'b0, {junk, 3'b000}, c, 1'b1, rd);
    colour = c[7:0];
    chk(busy == 0, "R1", "busy after colour write", int'(busy), 0);
    chk(req_cnt == r0, "R1", "requests on colour write", req_cnt - r0, 0);
  endtask

  task automatic stipple(input logic [AW-1:0] dst, input logic [31:0] m);
    logic [31:0] rd;
    int r0 = req_cnt;
    for (int i = 0; i < 32; i++) if (m[31-i]) exp_mem[(int'(dst) + i) % N] = colour;
    bus(1'b0, {dst, 3'b100}, m, 1'b1, rd);
    wait_busy(32, "R4");
    chk(req_cnt - r0 == $countones(m), "R3", "stipple writes", req_cnt - r0, $countones(m));
    mem_cmp("R3");
  endtask

  task automatic fill(input logic [AW-1:0] dst, input int len);
    logic [31:0] rd;
    for (int i = 0; i < len; i++) exp_mem[(int'(dst) + i) % N] = colour;
    bus(1'b1, {dst, 3'b100}, {3'b000, 5'(len - 1), 24'hFFFFFF}, 1'b1, rd);
    wait_busy(len, "R6");
    mem_cmp("R6");
  endtask

  task automatic copy(input logic [AW-1:0] dst, input logic [23:0] src, input int len);
    logic [31:0] rd;
    int s = int'(src) % N;
    int r0 = req_cnt;
    for (int i = 0; i < len; i++) exp_mem[(int'(dst) + i) % N] = exp_mem[(s + i) % N];
    bus(1'b1, {dst, 3'b100}, {3'b000, 5'(len - 1), src}, 1'b1, rd);
    wait_busy(2 * len, "R7");
    chk(req_cnt - r0 == 2 * len, "R7", "copy requests", req_cnt - r0, 2 * len);
    mem_cmp("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int r0, stall;
    for (int a = 0; a < N; a++) exp_mem[a] = pat(a);
    init_en = 1;
    repeat (2) @(negedge clk);
    init_en = 0;
    #1;
    chk(busy == 0, "R11", "busy in reset", int'(busy), 0);
    chk(cmd_ready == 1, "R11", "ready in reset", int'(cmd_ready), 1);
    chk(mem_req == 0, "R11", "request in reset", int'(mem_req), 0);
    @(negedge clk) rst_n = 1;
    mem_cmp("R11");

    fill(10'd5, 4);                 // colour is zero after reset (R11)

    set_colour(32'hABCD_EF5A, 10'h3F1);
    mem_cmp("R1");

    // R3 R4 R2: stipple mask sweep
    stipple(10'd0,   32'hFFFF_FFFF);
    set_colour(32'h0000_0033, 10'd7);
    stipple(10'd100, 32'h8000_0001);
    stipple(10'd200, 32'hA5A5_A5A5);
    stipple(10'd300, 32'h0000_0000);
    set_colour(32'h1234_56C7, 10'd0);
    stipple(10'd1010, 32'h1234_5678); // R10 wrap
    for (int b = 0; b < 32; b++) stipple(10'(320 + b * 3), 32'h1 << b);

    // R6: every run length
    for (int l = 1; l <= 32; l++) begin
      set_colour(32'(l * 5 + 1), 10'(l));
      fill(10'((l * 37) % N), l);
    end
    fill(10'd1000, 32);              // R10 wrap

    // R7 R5 R10: copies
    copy(10'd500, 24'd0, 32);
    copy(10'd203, 24'd200, 20);      // forward overlap
    copy(10'd205, 24'd210, 16);      // backward overlap
    copy(10'd700, 24'hABC123, 8);    // R5 upper source bits dropped
    copy(10'd600, 24'd1020, 10);     // R10 source wrap
    copy(10'd1020, 24'd40, 12);      // R10 destination wrap
    for (int l = 1; l <= 32; l += 5) copy(10'(l * 29), 24'(l * 11 + 3), l);

    // R8: reads
    for (int w = 0; w < 2; w++) begin
      r0 = req_cnt;
      bus(w[0], {10'd77, 3'b100}, 32'h1F00_0003, 1'b0, rd);
      chk(rd == 0, "R8", "read data", int'(rd), 0);
      chk(busy == 0, "R8", "busy after read", int'(busy), 0);
      chk(req_cnt == r0, "R8", "requests on read", req_cnt - r0, 0);
    end
    bus(1'b0, {10'd77, 3'b000}, 32'h0000_0099, 1'b0, rd);
    chk(rd == 0, "R8", "read data colour slot", int'(rd), 0);
    fill(10'd800, 3);                // colour must be unchanged by read (R8)

    // R9: command held valid during busy is stalled
    set_colour(32'h11, 10'd0);
    for (int i = 0; i < 16; i++) exp_mem[(850 + i) % N] = colour;
    bus(1'b0, {10'd850, 3'b100}, 32'hFFFF_0000, 1'b1, rd);
    cmd_valid = 1; cmd_win = 1; cmd_we = 1; cmd_addr = '0; cmd_wdata = 32'h77;
    stall = 0;
    while (!cmd_ready) begin stall++; @(negedge clk); end
    chk(stall == 32, "R9", "stall cycles", stall, 32);
    @(negedge clk);
    cmd_valid = 0; cmd_we = 0;
    colour = 8'h77;
    mem_cmp("R9");
    fill(10'd900, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule